// File: doc/BRIEF.md
# Per-Timeslot Channel Blocking Generator

This block produces per-timeslot gating signals for the receive and transmit halves of an E1 framer. Each half has a bit strobe and a frame-sync input; the block counts bits and timeslots from them and, for each of the 32 timeslots of a frame, drives that half's blocking output from a 32-bit channel mask that a host programs through a byte-wide register port. A typical use is gating the clock of an HDLC controller so that it sees only the selected timeslots.

A control register can switch the transmit half into a signaling-select mode. In that mode the transmit mask is read per voice channel (1 to 30, skipping the framing and signaling timeslots), and the block reports, for every timeslot, where the signaling for that timeslot should come from: the internal signaling registers, the serial data input, or a dedicated signaling pin. All outputs are registered and change only on the bit strobe that opens a timeslot.

Top module: `chan_gate_top`

## Requirements
- R1: Mask bytes are written when host_we is 1 and read back combinationally on host_rdata: transmit channels 1-8, 9-16, 17-24, 25-32 at addresses 0x22, 0x23, 0x24, 0x25 and receive channels in the same grouping at 0x2B, 0x2C, 0x2D, 0x2E, bit 0 of each byte being its lowest channel; the control byte is at 0x30 (bit 0 selects signaling-select mode, bit 1 selects the signaling pin, other bits read 0). Writes to any other address change nothing and other addresses read 0.
- R2: A bit strobe with frame sync high starts bit 0 of timeslot 0 on that side; otherwise every 8th strobe starts the next timeslot, wrapping from 31 to 0. After reset the first strobe starts timeslot 0. Channel n occupies timeslot n-1.
- R3: During timeslot t, rx_blk equals receive mask bit t (channel t+1) for all 8 bits of the timeslot and changes only on the strobe that opens a timeslot.
- R4: In normal mode tx_blk during timeslot t equals transmit mask bit t; the receive mask never affects tx_blk and the transmit mask never affects rx_blk.
- R5: A mask write in the middle of a timeslot does not alter that timeslot's output; it is applied from the next timeslot.
- R6: In signaling-select mode tx_blk is 0 and tx_sig_src is non-zero; in normal mode tx_sig_src is 0. Encoding: 0 none, 1 internal registers, 2 serial data input, 3 signaling pin.
- R7: In signaling-select mode, timeslots 1-15 carry voice channels 1-15 and timeslots 17-31 carry voice channels 16-30; voice channel v uses transmit mask bit v-1, and a 1 there gives tx_sig_src = 1.
- R8: In signaling-select mode timeslots 0 and 16 always report an external source (2 or 3), whatever the mask holds.
- R9: The external source reported is 2 when control bit 1 is 0 and 3 when it is 1.
- R10: After reset all registers read 0 and rx_blk, tx_blk and tx_sig_src are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Register byte address |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write enable |
| host_rdata | output | 8 | Read data for host_addr |
| rx_bit_stb | input | 1 | Receive bit strobe, one clk wide |
| rx_fsync | input | 1 | Receive frame sync, sampled with rx_bit_stb |
| rx_blk | output | 1 | Receive blocking output |
| tx_bit_stb | input | 1 | Transmit bit strobe, one clk wide |
| tx_fsync | input | 1 | Transmit frame sync, sampled with tx_bit_stb |
| tx_blk | output | 1 | Transmit blocking output |
| tx_sig_src | output | 2 | Signaling source for the current transmit timeslot |

## Verification
The bench builds the block with its default 32 timeslots of 8 bits, so a complete frame of 256 strobes is walked on each side and every timeslot, including the reserved timeslots 0 and 16 and the wrap from 31 to 0, is observed bit by bit. With these values the register map is the full nine bytes, so readback, ignored addresses, mid-timeslot mask writes and a frame sync arriving in the middle of a timeslot are all reachable in a few thousand cycles.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;

    localparam logic [7:0] ADDR_TX_BASE = 8'h22;
    localparam logic [7:0] ADDR_RX_BASE = 8'h2B;
    localparam logic [7:0] ADDR_CTRL    = 8'h30;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_INTERNAL = 2'd1,
        SRC_SERIAL   = 2'd2,
        SRC_PIN      = 2'd3
    } sig_src_e;

endpackage

// File: rtl/chan_gate_regs.sv
module chan_gate_regs
    import chan_gate_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           addr,
    input  logic [7:0]           wdata,
    input  logic                 we,
    output logic [7:0]           rdata,
    output logic [NUM_SLOTS-1:0] rx_mask,
    output logic [NUM_SLOTS-1:0] tx_mask,
    output logic                 alt_mode,
    output logic                 pin_sel
);

    localparam int NBYTES = NUM_SLOTS / 8;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] rx;
        logic [NUM_SLOTS-1:0] tx;
        logic                 alt;
        logic                 pin;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        rdata  = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == ADDR_TX_BASE + 8'(i)) begin
                rdata = regs_q.tx[i*8 +: 8];
                if (we) regs_d.tx[i*8 +: 8] = wdata;
            end
            if (addr == ADDR_RX_BASE + 8'(i)) begin
                rdata = regs_q.rx[i*8 +: 8];
                if (we) regs_d.rx[i*8 +: 8] = wdata;
            end
        end
        if (addr == ADDR_CTRL) begin
            rdata = {6'b0, regs_q.pin, regs_q.alt};
            if (we) begin
                regs_d.alt = wdata[0];
                regs_d.pin = wdata[1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rx_mask  = regs_q.rx;
    assign tx_mask  = regs_q.tx;
    assign alt_mode = regs_q.alt;
    assign pin_sel  = regs_q.pin;

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              fsync,
    output logic              slot_start,
    output logic [SLOT_W-1:0] next_slot,
    output logic [SLOT_W-1:0] slot_q,
    output logic [BIT_W-1:0]  bit_q
);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic start_d;

    always_comb begin
        cnt_d   = cnt_q;
        start_d = 1'b0;
        if (bit_stb) begin
            if (fsync) begin
                cnt_d.slot = '0;
                cnt_d.bitn = '0;
                start_d    = 1'b1;
            end else if (cnt_q.bitn == LAST_BIT) begin
                cnt_d.bitn = '0;
                cnt_d.slot = (cnt_q.slot == LAST_SLOT) ? '0 : cnt_q.slot + 1'b1;
                start_d    = 1'b1;
            end else begin
                cnt_d.bitn = cnt_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q.slot <= LAST_SLOT;
            cnt_q.bitn <= LAST_BIT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign slot_start = start_d;
    assign next_slot  = cnt_d.slot;
    assign slot_q     = cnt_q.slot;
    assign bit_q      = cnt_q.bitn;

endmodule

// File: rtl/tx_sig_sel.sv
module tx_sig_sel
    import chan_gate_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]    slot,
    input  logic [NUM_SLOTS-1:0] mask,
    input  logic                 pin_sel,
    output sig_src_e             src
);

    localparam logic [SLOT_W-1:0] SIG_SLOT = SLOT_W'(NUM_SLOTS / 2);

    logic [SLOT_W-1:0] voice_idx;
    sig_src_e          ext_src;

    always_comb begin
        ext_src   = pin_sel ? SRC_PIN : SRC_SERIAL;
        voice_idx = (slot < SIG_SLOT) ? slot - SLOT_W'(1) : slot - SLOT_W'(2);
        if (slot == '0 || slot == SIG_SLOT) src = ext_src;
        else if (mask[voice_idx])           src = SRC_INTERNAL;
        else                                src = ext_src;
    end

endmodule

// File: rtl/chan_gate_top.sv
module chan_gate_top
    import chan_gate_pkg::*;
#(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_we,
    output logic [7:0] host_rdata,
    input  logic       rx_bit_stb,
    input  logic       rx_fsync,
    output logic       rx_blk,
    input  logic       tx_bit_stb,
    input  logic       tx_fsync,
    output logic       tx_blk,
    output logic [1:0] tx_sig_src
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int BIT_W  = $clog2(BITS_PER_SLOT);

    logic [NUM_SLOTS-1:0] rx_mask, tx_mask;
    logic                 alt_mode, pin_sel;
    logic                 rx_start, tx_start;
    logic [SLOT_W-1:0]    rx_next, tx_next, rx_slot, tx_slot;
    logic [BIT_W-1:0]     rx_bit, tx_bit;
    sig_src_e             sel_src;

    typedef struct packed {
        logic     rx_blk;
        logic     tx_blk;
        sig_src_e tx_src;
    } out_t;

    out_t out_d, out_q;

    chan_gate_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .we       (host_we),
        .rdata    (host_rdata),
        .rx_mask  (rx_mask),
        .tx_mask  (tx_mask),
        .alt_mode (alt_mode),
        .pin_sel  (pin_sel)
    );

    slot_timer #(.NUM_SLOTS(NUM_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)) u_rx_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (rx_bit_stb),
        .fsync      (rx_fsync),
        .slot_start (rx_start),
        .next_slot  (rx_next),
        .slot_q     (rx_slot),
        .bit_q      (rx_bit)
    );

    slot_timer #(.NUM_SLOTS(NUM_SLOTS), .BITS_PER_SLOT(BITS_PER_SLOT)) u_tx_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (tx_bit_stb),
        .fsync      (tx_fsync),
        .slot_start (tx_start),
        .next_slot  (tx_next),
        .slot_q     (tx_slot),
        .bit_q      (tx_bit)
    );

    tx_sig_sel #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
        .slot    (tx_next),
        .mask    (tx_mask),
        .pin_sel (pin_sel),
        .src     (sel_src)
    );

    always_comb begin
        out_d = out_q;
        if (rx_start) out_d.rx_blk = rx_mask[rx_next];
        if (tx_start) begin
            if (alt_mode) begin
                out_d.tx_blk = 1'b0;
                out_d.tx_src = sel_src;
            end else begin
                out_d.tx_blk = tx_mask[tx_next];
                out_d.tx_src = SRC_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '{rx_blk: 1'b0, tx_blk: 1'b0, tx_src: SRC_NONE};
        else        out_q <= out_d;
    end

    assign rx_blk     = out_q.rx_blk;
    assign tx_blk     = out_q.tx_blk;
    assign tx_sig_src = out_q.tx_src;

endmodule

// File: rtl/chan_gate_chk.sv
module chan_gate_chk #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_bit_stb,
    input logic              rx_fsync,
    input logic              tx_bit_stb,
    input logic              tx_fsync,
    input logic              rx_blk,
    input logic              tx_blk,
    input logic [1:0]        tx_sig_src,
    input logic [SLOT_W-1:0] rx_slot,
    input logic [BIT_W-1:0]  rx_bit,
    input logic [SLOT_W-1:0] tx_slot,
    input logic [BIT_W-1:0]  tx_bit
);

    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] SIG_SLOT = SLOT_W'(NUM_SLOTS / 2);

    a_r3_rx_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_stb |=> $stable(rx_blk));

    a_r3_rx_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_stb && !rx_fsync && rx_bit != LAST_BIT) |=> $stable(rx_blk));

    a_r4_tx_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_stb && !tx_fsync && tx_bit != LAST_BIT) |=> ($stable(tx_blk) && $stable(tx_sig_src)));

    a_r2_rx_fsync_align: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_stb && rx_fsync) |=> (rx_slot == '0 && rx_bit == '0));

    a_r2_tx_fsync_align: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_stb && tx_fsync) |=> (tx_slot == '0 && tx_bit == '0));

    a_r6_alt_blk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sig_src != 2'd0) |-> !tx_blk);

    a_r8_reserved_external: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_slot == '0 || tx_slot == SIG_SLOT) |-> (tx_sig_src != 2'd1));

endmodule

bind chan_gate_top chan_gate_chk #(
    .NUM_SLOTS     (NUM_SLOTS),
    .BITS_PER_SLOT (BITS_PER_SLOT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit_stb (rx_bit_stb),
    .rx_fsync   (rx_fsync),
    .tx_bit_stb (tx_bit_stb),
    .tx_fsync   (tx_fsync),
    .rx_blk     (rx_blk),
    .tx_blk     (tx_blk),
    .tx_sig_src (tx_sig_src),
    .rx_slot    (rx_slot),
    .rx_bit     (rx_bit),
    .tx_slot    (tx_slot),
    .tx_bit     (tx_bit)
);

// File: tb/tb_chan_gate_top.sv
`timescale 1ns/1ps
module tb_chan_gate_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;
    logic       rx_bit_stb = 1'b0, rx_fsync = 1'b0, rx_blk;
    logic       tx_bit_stb = 1'b0, tx_fsync = 1'b0, tx_blk;
    logic [1:0] tx_sig_src;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    chan_gate_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_rdata (host_rdata),
        .rx_bit_stb (rx_bit_stb),
        .rx_fsync   (rx_fsync),
        .rx_blk     (rx_blk),
        .tx_bit_stb (tx_bit_stb),
        .tx_fsync   (tx_fsync),
        .tx_blk     (tx_blk),
        .tx_sig_src (tx_sig_src)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1;
        check(req, {24'b0, host_rdata}, {24'b0, exp});
    endtask

    task automatic wr_mask(input logic [7:0] base, input logic [31:0] m);
        for (int i = 0; i < 4; i++) wr(base + 8'(i), m[i*8 +: 8]);
    endtask

    // one strobe, then one idle cycle; returns at a negedge after the update
    task automatic rx_step(input logic fs);
        @(negedge clk);
        rx_bit_stb = 1'b1; rx_fsync = fs;
        @(negedge clk);
        rx_bit_stb = 1'b0; rx_fsync = 1'b0;
    endtask

    task automatic tx_step(input logic fs);
        @(negedge clk);
        tx_bit_stb = 1'b1; tx_fsync = fs;
        @(negedge clk);
        tx_bit_stb = 1'b0; tx_fsync = 1'b0;
    endtask

    function automatic logic [1:0] exp_src(input int t, input logic [31:0] m, input logic pin);
        logic [1:0] ext;
        int idx;
        ext = pin ? 2'd3 : 2'd2;
        if (t == 0 || t == 16) return ext;
        idx = (t < 16) ? t - 1 : t - 2;
        return m[idx] ? 2'd1 : ext;
    endfunction

    task automatic t_reset;
        check("R10 rx_blk", {31'b0, rx_blk}, 0);
        check("R10 tx_blk", {31'b0, tx_blk}, 0);
        check("R10 tx_sig_src", {30'b0, tx_sig_src}, 0);
        rd_check("R10 reg 0x22", 8'h22, 8'h00);
        rd_check("R10 reg 0x2E", 8'h2E, 8'h00);
        rd_check("R10 reg 0x30", 8'h30, 8'h00);
    endtask

    task automatic t_regs;
        wr_mask(8'h22, 32'h4433_2211);
        wr_mask(8'h2B, 32'h8877_6655);
        wr(8'h30, 8'hFF);
        rd_check("R1 tx byte0", 8'h22, 8'h11);
        rd_check("R1 tx byte3", 8'h25, 8'h44);
        rd_check("R1 rx byte0", 8'h2B, 8'h55);
        rd_check("R1 rx byte2", 8'h2D, 8'h77);
        rd_check("R1 ctrl", 8'h30, 8'h03);
        wr(8'h26, 8'hAA);
        wr(8'h2A, 8'hAA);
        wr(8'h2F, 8'hAA);
        rd_check("R1 unused 0x26", 8'h26, 8'h00);
        rd_check("R1 unused 0x2F", 8'h2F, 8'h00);
        rd_check("R1 neighbour 0x25 intact", 8'h25, 8'h44);
        rd_check("R1 neighbour 0x2E intact", 8'h2E, 8'h88);
        wr(8'h30, 8'h00);
    endtask

    task automatic t_rx_frame(input logic [31:0] m);
        wr_mask(8'h2B, m);
        wr_mask(8'h22, 32'h0);
        for (int t = 0; t < 32; t++)
            for (int b = 0; b < 8; b++) begin
                rx_step(t == 0 && b == 0);
                check($sformatf("R3 rx slot %0d bit %0d", t, b), {31'b0, rx_blk}, {31'b0, m[t]});
                if (b == 0) check("R4 tx_blk ignores rx mask", {31'b0, tx_blk}, 0);
            end
        rx_step(1'b0);
        check("R2 rx wrap to slot 0", {31'b0, rx_blk}, {31'b0, m[0]});
    endtask

    task automatic t_tx_frame(input logic [31:0] m);
        wr_mask(8'h22, m);
        wr_mask(8'h2B, 32'h0);
        for (int t = 0; t < 32; t++)
            for (int b = 0; b < 8; b++) begin
                tx_step(t == 0 && b == 0);
                check($sformatf("R4 tx slot %0d bit %0d", t, b), {31'b0, tx_blk}, {31'b0, m[t]});
                if (b == 0) begin
                    check("R6 normal mode src none", {30'b0, tx_sig_src}, 0);
                    rx_step(t == 0);
                    check("R4 rx_blk ignores tx mask", {31'b0, rx_blk}, 0);
                end
            end
    endtask

    task automatic t_midslot;
        wr_mask(8'h2B, 32'h0000_0002);
        rx_step(1'b1);
        check("R5 slot0 before write", {31'b0, rx_blk}, 0);
        rx_step(1'b0);
        wr_mask(8'h2B, 32'h0000_0001);
        for (int b = 2; b < 8; b++) begin
            rx_step(1'b0);
            check("R5 slot0 unchanged after mid-slot write", {31'b0, rx_blk}, 0);
        end
        rx_step(1'b0);
        check("R5 slot1 uses new mask", {31'b0, rx_blk}, 0);
        wr_mask(8'h2B, 32'h0000_0004);
        for (int b = 1; b < 8; b++) rx_step(1'b0);
        check("R5 slot1 held low", {31'b0, rx_blk}, 0);
        rx_step(1'b0);
        check("R5 slot2 high from new mask", {31'b0, rx_blk}, 1);
    endtask

    task automatic t_fsync_mid;
        wr_mask(8'h2B, 32'h0000_0001);
        for (int k = 0; k < 13; k++) rx_step(1'b0);
        check("R2 mid-frame slot low", {31'b0, rx_blk}, 0);
        rx_step(1'b1);
        check("R2 fsync realigns to slot 0", {31'b0, rx_blk}, 1);
        for (int b = 1; b < 8; b++) rx_step(1'b0);
        rx_step(1'b0);
        check("R2 slot 1 follows 8 strobes later", {31'b0, rx_blk}, 0);
    endtask

    task automatic t_alt(input logic [31:0] m, input logic pin);
        wr_mask(8'h22, m);
        wr(8'h30, {6'b0, pin, 1'b1});
        for (int t = 0; t < 32; t++)
            for (int b = 0; b < 8; b++) begin
                tx_step(t == 0 && b == 0);
                if (b == 0 || b == 7) begin
                    check($sformatf("R7 R8 R9 src slot %0d", t), {30'b0, tx_sig_src},
                          {30'b0, exp_src(t, m, pin)});
                    check("R6 alt tx_blk low", {31'b0, tx_blk}, 0);
                end
            end
        wr(8'h30, 8'h00);
        tx_step(1'b1);
        check("R6 back to normal src", {30'b0, tx_sig_src}, 0);
        check("R4 back to normal blk", {31'b0, tx_blk}, {31'b0, m[0]});
    endtask

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rx_frame(32'hA5C3_0F96);
        t_rx_frame(32'h8000_0001);
        t_tx_frame(32'h3C5A_E187);
        t_midslot();
        t_fsync_mid();
        t_alt(32'hFFFF_FFFF, 1'b0);
        t_alt(32'h2D4B_96A5, 1'b1);
        t_alt(32'h0000_0000, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule